// File: doc/BRIEF.md
# Periodic Wakeup Down-Counter

This block raises a periodic wakeup event from a slow time base. A down-counter restarts from a programmable reload value. It decrements on each tick of a selectable time source. When a tick arrives while the count is zero, the counter sets a sticky wakeup flag and loads the reload value again in that same tick. The time source is either the slow clock divided by 16, 8, 4 or 2, or an undivided once-per-second style tick input.

The slow clock reaches the block as a single-cycle enable pulse, `slow_en`, on the system clock. The run enable passes through a synchronizer that advances only on `slow_en`. The reload value and source selection can change only while the timer is stopped. To reconfigure, software clears `cfg_en` and waits for `wr_allowed`. That flag goes high only after the stop has crossed the synchronizer. Software then writes the new settings and sets `cfg_en` again. Writes made while `wr_allowed` is low are lost.

Top module: `wkup_timer`

## Requirements
- R1: After reset, `wr_allowed` is 1, `wake_flag` is 0, and no wakeup occurs while `cfg_en` stays 0, whatever `slow_en` and `sec_tick` do.
- R2: When `cfg_en` is sampled high at a clock edge, `wr_allowed` is 0 after that edge.
- R3: After `cfg_en` is cleared on a running timer, `wr_allowed` stays 0 until two `slow_en` pulses have been sampled. It becomes 1 one clock cycle after the second of those pulses.
- R4: A write (`wr_valid` high) takes effect only in a cycle where `wr_allowed` is 1. Writes in other cycles change neither the reload value nor the selection.
- R5: Selection codes 0, 1, 2 and 3 (`wr_sel[2]` = 0) produce one count tick every 16, 8, 4 and 2 `slow_en` pulses respectively.
- R6: Selection codes 4 to 7 (`wr_sel[2]` = 1) use each `sec_tick` pulse as one count tick and ignore `slow_en` for counting.
- R7: With reload value N, exactly one wakeup occurs every N+1 count ticks. With N = 0, every tick wakes.
- R8: On each enable, the count restarts from the reload value and does not resume where it stopped.
- R9: `wake_flag` stays high until `flag_clr` is asserted. A wakeup in the same cycle as `flag_clr` leaves the flag set.
- R10: Ticks that arrive while the timer is stopped do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle pulse per slow-clock period |
| sec_tick | input | 1 | One-cycle undivided tick, used by codes 4 to 7 |
| cfg_en | input | 1 | Timer run enable |
| wr_valid | input | 1 | Write strobe for reload value and selection |
| wr_reload | input | 16 | Reload value to write |
| wr_sel | input | 3 | Time source selection to write |
| flag_clr | input | 1 | Clears the wakeup flag |
| wr_allowed | output | 1 | Configuration may be written |
| wake_flag | output | 1 | Sticky wakeup flag |

## Verification
The bench takes `wr_allowed` through a full disable and counts `slow_en` pulses. A design that raised the flag before the stop had crossed the synchronizer fails on the exact rise cycle. Writes are sent both while the timer runs and in the gap after disable. The wakeup period is then measured, so a design that accepted those writes shows a different interval. Manual ticks are issued before a stop, during it and after a restart. A counter that resumed where it stopped, or that counted stopped ticks, wakes one or two ticks too early. With a reload of zero, a wakeup is placed in the same cycle as a clear, which exposes a design where the clear wins.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

   // Terminal value of the prescaler for a divided-source code.
   function automatic int unsigned presc_last(input int unsigned code,
                                              input int unsigned top_log);
      return (1 << (top_log - code)) - 1;
   endfunction

endpackage

// File: rtl/wkup_sync.sv
module wkup_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_en,
   input  logic cfg_en,
   output logic run,
   output logic wr_allowed
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkup_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q       <= '0;
         wr_allowed <= 1'b1;
      end else begin
         if (slow_en) sh_q <= {sh_q[STAGES-2:0], cfg_en};
         // open only when the request is low and every stage has drained
         wr_allowed <= !cfg_en && (sh_q == '0);
      end
   end

   assign run = sh_q[STAGES-1];
endmodule

// File: rtl/wkup_presc.sv
module wkup_presc #(
   parameter int unsigned SEL_W   = 3,
   parameter int unsigned TOP_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             slow_en,
   input  logic             sec_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   import wkup_pkg::*;
   localparam int unsigned NDIV = 1 << (SEL_W - 1);

   logic [TOP_LOG-1:0] lim [NDIV];
   logic [TOP_LOG-1:0] div_q;
   logic [TOP_LOG-1:0] last;
   logic               direct;

   generate
      if (SEL_W < 2) begin : g_bad_sel
         $error("wkup_presc needs a selection of two or more bits");
      end
      if (TOP_LOG < NDIV) begin : g_bad_log
         $error("wkup_presc: TOP_LOG too small for the divided codes");
      end
      for (genvar c = 0; c < NDIV; c++) begin : g_lim
         assign lim[c] = TOP_LOG'(presc_last(c, TOP_LOG));
      end
   endgenerate

   assign direct = sel[SEL_W-1];
   assign last   = lim[sel[SEL_W-2:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  div_q <= '0;
      else if (!run)               div_q <= '0;
      else if (slow_en && !direct) div_q <= (div_q == last) ? '0 : div_q + 1'b1;
   end

   assign tick = run && (direct ? sec_tick : (slow_en && (div_q == last)));
endmodule

// File: rtl/wkup_count.sv
module wkup_count #(
   parameter int unsigned RLD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [RLD_W-1:0] reload,
   input  logic             flag_clr,
   output logic [RLD_W-1:0] cnt_q,
   output logic             wake_flag
);
   logic at_zero;
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '1;
      else if (!run)    cnt_q <= reload;
      else if (tick)    cnt_q <= at_zero ? reload : cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        wake_flag <= 1'b0;
      else if (run && tick && at_zero)   wake_flag <= 1'b1;
      else if (flag_clr)                 wake_flag <= 1'b0;
   end
endmodule

// File: rtl/wkup_timer.sv
module wkup_timer #(
   parameter int unsigned RLD_W       = 16,
   parameter int unsigned SEL_W       = 3,
   parameter int unsigned TOP_LOG     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_en,
   input  logic             sec_tick,
   input  logic             cfg_en,
   input  logic             wr_valid,
   input  logic [RLD_W-1:0] wr_reload,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             flag_clr,
   output logic             wr_allowed,
   output logic             wake_flag
);
   logic [RLD_W-1:0] cfg_reload_q;
   logic [SEL_W-1:0] cfg_sel_q;
   logic [RLD_W-1:0] count_q;
   logic             run_s;
   logic             tick_s;

   generate
      if (RLD_W < 2) begin : g_bad_rld
         $error("wkup_timer: reload width too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_reload_q <= '1;
         cfg_sel_q    <= '0;
      end else if (wr_valid && wr_allowed) begin
         cfg_reload_q <= wr_reload;
         cfg_sel_q    <= wr_sel;
      end
   end

   wkup_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .cfg_en(cfg_en),
      .run(run_s), .wr_allowed(wr_allowed)
   );

   wkup_presc #(.SEL_W(SEL_W), .TOP_LOG(TOP_LOG)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run_s), .slow_en(slow_en),
      .sec_tick(sec_tick), .sel(cfg_sel_q), .tick(tick_s)
   );

   wkup_count #(.RLD_W(RLD_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run(run_s), .tick(tick_s),
      .reload(cfg_reload_q), .flag_clr(flag_clr),
      .cnt_q(count_q), .wake_flag(wake_flag)
   );
endmodule

// File: rtl/wkup_timer_chk.sv
module wkup_timer_chk #(
   parameter int unsigned RLD_W = 16,
   parameter int unsigned SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic             flag_clr,
   input logic             wr_allowed,
   input logic             wake_flag,
   input logic             run_s,
   input logic [RLD_W-1:0] cfg_reload_q,
   input logic [SEL_W-1:0] cfg_sel_q,
   input logic [RLD_W-1:0] count_q
);
   a_r2_closed_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> !wr_allowed);

   a_r3_closed_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      wr_allowed |-> !run_s);

   a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_allowed |=> ($stable(cfg_reload_q) && $stable(cfg_sel_q)));

   a_r7_reload_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> (count_q == cfg_reload_q));

   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && !flag_clr) |=> wake_flag);
endmodule

bind wkup_timer wkup_timer_chk #(.RLD_W(RLD_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .flag_clr(flag_clr),
   .wr_allowed(wr_allowed), .wake_flag(wake_flag), .run_s(run_s),
   .cfg_reload_q(cfg_reload_q), .cfg_sel_q(cfg_sel_q), .count_q(count_q)
);

// File: tb/wkup_timer_test.sv
`timescale 1ns/1ps
module wkup_timer_test;
   localparam int SLOW_P = 4;
   localparam int SEC_P  = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic slow_en = 1'b0, sec_tick = 1'b0, cfg_en = 1'b0, wr_valid = 1'b0;
   logic [15:0] wr_reload = '0;
   logic [2:0]  wr_sel = '0;
   logic flag_clr = 1'b0, wr_allowed, wake_flag;
   logic auto_sec = 1'b0, man_tick = 1'b0, done = 1'b0;
   int vectors = 0, fails = 0, cyc = 0, sdiv = 0, tdiv = 0;

   always #2.5 clk = ~clk;

   wkup_timer uut (
      .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .sec_tick(sec_tick),
      .cfg_en(cfg_en), .wr_valid(wr_valid), .wr_reload(wr_reload),
      .wr_sel(wr_sel), .flag_clr(flag_clr), .wr_allowed(wr_allowed),
      .wake_flag(wake_flag)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      slow_en = (sdiv == 0);
      sdiv    = (sdiv + 1) % SLOW_P;
      sec_tick = auto_sec ? (tdiv == 0) : man_tick;
      tdiv    = (tdiv + 1) % SEC_P;
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; step(1); flag_clr = 1'b0;
   endtask

   task automatic man_pulse();
      man_tick = 1'b1; step(1); man_tick = 1'b0; step(1);
   endtask

   task automatic program_cfg(input int r, input int s);
      cfg_en = 1'b0;
      while (!wr_allowed) step(1);
      wr_valid = 1'b1; wr_reload = 16'(r); wr_sel = 3'(s);
      step(1);
      wr_valid = 1'b0;
   endtask

   task automatic measure(input string req, input int exp);
      int t1;
      clear_flag();
      while (!wake_flag) step(1);
      t1 = cyc;
      clear_flag();
      while (!wake_flag) step(1);
      check(req, cyc - t1, exp);
   endtask

   task automatic test_reset();
      check("R1 wr_allowed", wr_allowed, 1);
      check("R1 wake_flag", wake_flag, 0);
      auto_sec = 1'b1;
      step(100);
      check("R1 no wake while disabled", wake_flag, 0);
      auto_sec = 1'b0;
   endtask

   task automatic test_handshake();
      int pulses = 0, early = 0;
      program_cfg(3, 0);
      cfg_en = 1'b1; step(1);
      check("R2 closed after enable", wr_allowed, 0);
      step(12);
      cfg_en = 1'b0;
      while (pulses < 2) begin
         step(1);
         if (slow_en) pulses++;
         if (wr_allowed) early++;
      end
      check("R3 not open before second pulse", early, 0);
      step(1);
      check("R3 open one cycle after second pulse", wr_allowed, 1);
   endtask

   task automatic test_dropped_write();
      program_cfg(3, 3);
      cfg_en = 1'b1; step(1);
      wr_valid = 1'b1; wr_reload = 16'd9; wr_sel = 3'd0; step(1); wr_valid = 1'b0;
      measure("R4 write while running dropped", 4 * 2 * SLOW_P);
      cfg_en = 1'b0; step(1);
      wr_valid = 1'b1; wr_reload = 16'd9; wr_sel = 3'd0; step(1); wr_valid = 1'b0;
      while (!wr_allowed) step(1);
      cfg_en = 1'b1;
      measure("R4 write in sync gap dropped", 4 * 2 * SLOW_P);
   endtask

   task automatic test_dividers();
      for (int c = 0; c < 4; c++) begin
         program_cfg(2, c);
         cfg_en = 1'b1;
         measure($sformatf("R5 code %0d", c), 3 * (16 >> c) * SLOW_P);
      end
   endtask

   task automatic test_direct();
      auto_sec = 1'b1;
      program_cfg(4, 4); cfg_en = 1'b1;
      measure("R6 code 4", 5 * SEC_P);
      program_cfg(4, 7); cfg_en = 1'b1;
      measure("R6 code 7", 5 * SEC_P);
      cfg_en = 1'b0;
      auto_sec = 1'b0;
   endtask

   task automatic test_restart();
      program_cfg(3, 5);
      cfg_en = 1'b1; step(12);
      clear_flag();
      repeat (3) man_pulse();
      check("R7 no wake after N ticks", wake_flag, 0);
      man_pulse();
      check("R7 wake on tick N+1", wake_flag, 1);
      step(20);
      check("R9 flag sticky", wake_flag, 1);
      clear_flag();
      check("R9 flag cleared", wake_flag, 0);
      repeat (2) man_pulse();
      cfg_en = 1'b0;
      while (!wr_allowed) step(1);
      repeat (2) man_pulse();
      check("R10 no wake from stopped ticks", wake_flag, 0);
      cfg_en = 1'b1; step(12);
      repeat (3) man_pulse();
      check("R8 restart from reload, no early wake", wake_flag, 0);
      man_pulse();
      check("R8 wake after full period", wake_flag, 1);
   endtask

   task automatic test_zero_reload();
      program_cfg(0, 6);
      cfg_en = 1'b1; step(12);
      clear_flag();
      man_pulse();
      check("R7 zero reload wakes each tick", wake_flag, 1);
      clear_flag();
      check("R9 clear", wake_flag, 0);
      man_tick = 1'b1; flag_clr = 1'b1; step(1);
      man_tick = 1'b0; flag_clr = 1'b0; step(1);
      check("R9 wake beats clear", wake_flag, 1);
      cfg_en = 1'b0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      test_reset();
      test_handshake();
      test_dropped_write();
      test_dividers();
      test_direct();
      test_restart();
      test_zero_reload();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule